// File: doc/BRIEF.md
# Multiplier-Free QPSK Phase Selector

This block turns a 16-bit data word into a digital QPSK carrier without any multiplication. It holds one sine table of `LUT_DEPTH` samples. Four taps read that table at the running sample index plus a fixed quarter-cycle offset of 0, 1, 2 or 3. A multiplexer then picks the tap that belongs to the current two-bit symbol. Each symbol lasts exactly one carrier cycle. The eight symbols of a word are sent one after another as a continuous sample stream. When the last sample of a word goes out and enable is still high, the next word is taken in at once, so no gap appears between words.

The block runs on a single clock. It has an asynchronous active-low reset whose release is synchronised inside the block. `en` acts as a clock enable for the whole datapath: while it is low the stream stops where it is and the output reads zero. When `en` returns high the stream continues from the sample where it stopped. The output samples are signed two's-complement values that go to a later converter stage.

Top module: `qpsk_mux_mod`

## Requirements
- R1: After reset `sample_out` is 0. The first edge with `en` high then loads `data_in` and starts at symbol 0, table index 0. Reset assertion takes effect immediately. Reset release takes effect after two clock edges.
- R2: Table entry k (0 <= k < LUT_DEPTH) has the value +/-round(A*16j(H-j)/(5H^2-4j(H-j))). Here H = LUT_DEPTH/2, j = k mod H, A = 2^(SAMPLE_W-1)-1, and the sign is negative when k >= H. With the defaults, entry 4 is +127, entry 12 is -127 and entry 1 is +49. The output never lies outside [-A, +A].
- R3: The symbol value s = {bit hi, bit lo} picks a phase offset that is added modulo LUT_DEPTH to the running index: 2'b00 gives 0, 2'b10 gives LUT_DEPTH/4 (90 degrees), 2'b01 gives LUT_DEPTH/2 (180 degrees), and 2'b11 gives 3*LUT_DEPTH/4 (270 degrees).
- R4: A word is sent as DATA_W/2 symbols, starting with the most significant pair (bits 15:14), then bits 13:12, and so on.
- R5: Each symbol lasts exactly LUT_DEPTH enabled cycles. It starts at running index 0, so a new phase takes effect only at a carrier-cycle boundary.
- R6: The sample for the state present at an enabled edge appears on `sample_out` after that edge. This is one register of latency.
- R7: An edge with `en` low drives `sample_out` to 0 and leaves the index, the symbol count and the held word unchanged. The stream resumes from the same point when `en` returns high.
- R8: On the enabled edge that sends the last sample of the last symbol, `data_in` is loaded as the next word. The new word's first sample follows on the very next enabled edge.
- R9: `data_in` has no effect on the output except on the edges that load a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside the block |
| en | input | 1 | Stream enable, clock enable for the whole datapath |
| data_in | input | DATA_W (16) | Word to send, sampled only on load edges |
| sample_out | output | SAMPLE_W (8) | Signed carrier sample |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 16-entry table and 8-bit samples. With these values a word takes 128 enabled cycles, so full words, word boundaries and back-to-back loads all fit in a short run. The table values at indices 1, 4 and 12 are small enough to check by hand against the closed-form sine rule. The quarter-cycle offsets land on whole indices, so every phase in the mapping reaches an exact peak or zero crossing. Enable is toggled in a pseudo-random pattern in the middle of symbols, while `data_in` changes on every cycle, so both stalls and the timing of word loads are exercised.

// File: rtl/qpsk_pkg.sv
package qpsk_pkg;

  // Closed-form sine approximation over one half cycle, odd-symmetric over the second half.
  function automatic logic signed [31:0] sine_level(input int k, input int depth, input int amp);
    longint half;
    longint j;
    longint num;
    longint den;
    longint mag;
    half = longint'(depth / 2);
    j    = longint'(k % depth);
    if (j >= half) j = j - half;
    num = 64'sd16 * j * (half - j);
    den = 64'sd5 * half * half - 64'sd4 * j * (half - j);
    mag = (64'sd2 * longint'(amp) * num + den) / (64'sd2 * den);
    if ((k % depth) >= (depth / 2)) mag = -mag;
    return mag[31:0];
  endfunction

  // Symbol pair to phase quadrant: the two bits read in reverse order.
  function automatic logic [1:0] pair_to_quadrant(input logic [1:0] pair);
    return {pair[0], pair[1]};
  endfunction

endpackage

// File: rtl/qpsk_symbol_seq.sv
module qpsk_symbol_seq #(
  parameter int DATA_W    = 16,
  parameter int LUT_DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en,
  input  logic [DATA_W-1:0]                 data_in,
  output logic                              active_o,
  output logic [$clog2(LUT_DEPTH)-1:0]      idx_o,
  output logic [$clog2(DATA_W/2)-1:0]       sym_o,
  output logic [DATA_W-1:0]                 word_o
);
  localparam int NSYM  = DATA_W / 2;
  localparam int IDX_W = $clog2(LUT_DEPTH);
  localparam int SYM_W = $clog2(NSYM);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LUT_DEPTH - 1);
  localparam logic [SYM_W-1:0] SYM_LAST = SYM_W'(NSYM - 1);

  logic              active_q, active_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [SYM_W-1:0]  sym_q, sym_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              cyc_end, word_end, load, step;

  always_comb begin
    cyc_end  = (idx_q == IDX_LAST);
    word_end = cyc_end && (sym_q == SYM_LAST);
    load     = en && (!active_q || word_end);
    step     = en && active_q;
    active_d = active_q;
    idx_d    = idx_q;
    sym_d    = sym_q;
    word_d   = word_q;
    if (load) begin
      active_d = 1'b1;
      idx_d    = '0;
      sym_d    = '0;
      word_d   = data_in;
    end else if (step) begin
      idx_d = idx_q + 1'b1;
      if (cyc_end) begin
        sym_d  = sym_q + 1'b1;
        word_d = {word_q[DATA_W-3:0], 2'b00};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      sym_q    <= '0;
      word_q   <= '0;
    end else if (en) begin
      active_q <= active_d;
      idx_q    <= idx_d;
      sym_q    <= sym_d;
      word_q   <= word_d;
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign sym_o    = sym_q;
  assign word_o   = word_q;
endmodule

// File: rtl/qpsk_phase_taps.sv
module qpsk_phase_taps #(
  parameter int LUT_DEPTH = 16,
  parameter int SAMPLE_W  = 8
) (
  input  logic [$clog2(LUT_DEPTH)-1:0]  idx,
  output logic [3:0][SAMPLE_W-1:0]      taps
);
  localparam int IDX_W = $clog2(LUT_DEPTH);
  localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;

  logic [SAMPLE_W-1:0] tbl [LUT_DEPTH];

  for (genvar k = 0; k < LUT_DEPTH; k++) begin : g_tbl
    localparam logic signed [31:0] LVL = qpsk_pkg::sine_level(k, LUT_DEPTH, AMP);
    assign tbl[k] = LVL[SAMPLE_W-1:0];
  end

  for (genvar p = 0; p < 4; p++) begin : g_tap
    localparam logic [IDX_W-1:0] OFF = IDX_W'((p * LUT_DEPTH) / 4);
    logic [IDX_W-1:0] tap_idx;
    assign tap_idx = idx + OFF;
    assign taps[p] = tbl[tap_idx];
  end
endmodule

// File: rtl/qpsk_phase_mux.sv
module qpsk_phase_mux #(
  parameter int SAMPLE_W = 8
) (
  input  logic [1:0]                 pair,
  input  logic [3:0][SAMPLE_W-1:0]   taps,
  output logic [SAMPLE_W-1:0]        sample
);
  logic [1:0] quad;

  always_comb begin
    quad = qpsk_pkg::pair_to_quadrant(pair);
    unique case (quad)
      2'd0:    sample = taps[0];
      2'd1:    sample = taps[1];
      2'd2:    sample = taps[2];
      default: sample = taps[3];
    endcase
  end
endmodule

// File: rtl/qpsk_mux_mod.sv
module qpsk_mux_mod #(
  parameter int DATA_W    = 16,
  parameter int LUT_DEPTH = 16,
  parameter int SAMPLE_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [DATA_W-1:0]   data_in,
  output logic [SAMPLE_W-1:0] sample_out
);
  localparam int NSYM  = DATA_W / 2;
  localparam int IDX_W = $clog2(LUT_DEPTH);
  localparam int SYM_W = $clog2(NSYM);

  if ((LUT_DEPTH < 4) || ((LUT_DEPTH & (LUT_DEPTH - 1)) != 0)) begin : g_bad_depth
    $error("LUT_DEPTH must be a power of two of at least 4");
  end
  if ((DATA_W < 4) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_width
    $error("DATA_W must be a power of two of at least 4");
  end

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                        active;
  logic [IDX_W-1:0]            idx;
  logic [SYM_W-1:0]            sym;
  logic [DATA_W-1:0]           word;
  logic [3:0][SAMPLE_W-1:0]    taps;
  logic [SAMPLE_W-1:0]         mux_sample;
  logic [SAMPLE_W-1:0]         out_d, out_q;

  qpsk_symbol_seq #(.DATA_W(DATA_W), .LUT_DEPTH(LUT_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .en(en), .data_in(data_in),
    .active_o(active), .idx_o(idx), .sym_o(sym), .word_o(word)
  );

  qpsk_phase_taps #(.LUT_DEPTH(LUT_DEPTH), .SAMPLE_W(SAMPLE_W)) u_taps (
    .idx(idx), .taps(taps)
  );

  qpsk_phase_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
    .pair(word[DATA_W-1 -: 2]), .taps(taps), .sample(mux_sample)
  );

  always_comb begin
    out_d = '0;
    if (en && active) out_d = mux_sample;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_q <= '0;
    else            out_q <= out_d;
  end

  assign sample_out = out_q;
endmodule

// File: rtl/qpsk_mux_mod_chk.sv
module qpsk_mux_mod_chk #(
  parameter int DATA_W    = 16,
  parameter int LUT_DEPTH = 16,
  parameter int SAMPLE_W  = 8
) (
  input logic                          clk,
  input logic                          rst_int_n,
  input logic                          en,
  input logic [DATA_W-1:0]             data_in,
  input logic [SAMPLE_W-1:0]           sample_out,
  input logic                          active,
  input logic [$clog2(LUT_DEPTH)-1:0]  idx,
  input logic [$clog2(DATA_W/2)-1:0]   sym,
  input logic [DATA_W-1:0]             word
);
  localparam int IDX_W = $clog2(LUT_DEPTH);
  localparam int SYM_W = $clog2(DATA_W / 2);
  localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LUT_DEPTH - 1);
  localparam logic [SYM_W-1:0] SYM_LAST = SYM_W'(DATA_W / 2 - 1);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en |=> (sample_out == '0));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !en |=> ($stable(idx) && $stable(sym) && $stable(word)));

  p_sym_hold_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en && active && idx != IDX_LAST) |=> ($stable(sym) && $stable(word)));

  p_sym_step_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en && active && idx == IDX_LAST && sym != SYM_LAST) |=>
      (sym == $past(sym) + 1'b1 && idx == '0));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en && (!active || (idx == IDX_LAST && sym == SYM_LAST))) |=>
      (word == $past(data_in) && idx == '0 && sym == '0 && active));

  p_amp_bound_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($signed(sample_out) >= -AMP) && ($signed(sample_out) <= AMP));
endmodule

bind qpsk_mux_mod qpsk_mux_mod_chk #(
  .DATA_W(DATA_W), .LUT_DEPTH(LUT_DEPTH), .SAMPLE_W(SAMPLE_W)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .en(en), .data_in(data_in),
  .sample_out(sample_out), .active(active), .idx(idx), .sym(sym), .word(word)
);

// File: tb/tb_qpsk_mux_mod.sv
module tb_qpsk_mux_mod;
  localparam int DW   = 16;
  localparam int N    = 16;
  localparam int SW   = 8;
  localparam int AMPL = 127;

  logic          clk;
  logic          rst_n;
  logic          en;
  logic [DW-1:0] data_in;
  logic [SW-1:0] sample_out;

  qpsk_mux_mod #(.DATA_W(DW), .LUT_DEPTH(N), .SAMPLE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .data_in(data_in), .sample_out(sample_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";
  bit    cmp_on   = 1'b0;

  // Reference table from the closed-form rule of R2.
  function automatic int ref_level(input int k);
    int h, j, s, mag;
    h = N / 2;
    j = k % N;
    s = 1;
    if (j >= h) begin j = j - h; s = -1; end
    mag = (2 * AMPL * 16 * j * (h - j) + (5 * h * h - 4 * j * (h - j)))
          / (2 * (5 * h * h - 4 * j * (h - j)));
    return s * mag;
  endfunction

  // Quadrant per R3: 00->0, 10->1, 01->2, 11->3
  function automatic int quad_of(input logic [1:0] pr);
    case (pr)
      2'b00:   return 0;
      2'b10:   return 1;
      2'b01:   return 2;
      default: return 3;
    endcase
  endfunction

  // Behavioural reference, advanced on every edge.
  bit            m_active;
  int            m_idx, m_sym;
  logic [DW-1:0] m_word;
  int            exp_val;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 1'b0; m_idx = 0; m_sym = 0; m_word = '0; exp_val = 0;
    end else begin
      if (en && m_active) exp_val = ref_level((m_idx + quad_of(m_word[DW-1 -: 2]) * N / 4) % N);
      else                exp_val = 0;
      if (en) begin
        if (!m_active || (m_idx == N - 1 && m_sym == DW / 2 - 1)) begin
          m_active = 1'b1; m_idx = 0; m_sym = 0; m_word = data_in;
        end else begin
          if (m_idx == N - 1) begin
            m_idx = 0; m_sym = m_sym + 1; m_word = m_word << 2;
          end else m_idx = m_idx + 1;
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: sample_out=%0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) check(tag, int'($signed(sample_out)), exp_val);
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic do_reset();
    cmp_on = 1'b0;
    rst_n = 1'b0; en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; data_in = '0;
    do_reset();
    // R1: output zero after reset
    check("R1", int'($signed(sample_out)), 0);

    // R3/R6: word 8000 -> first symbol 90 degrees, first sample = table[4] = +127
    data_in = 16'h8000; en = 1'b1;
    @(negedge clk);
    check("R6", int'($signed(sample_out)), 0);
    @(negedge clk);
    check("R3", int'($signed(sample_out)), 127);
    @(negedge clk);
    check("R2", int'($signed(sample_out)), ref_level(5));
    tag = "R5"; cmp_on = 1'b1;
    // R9: data_in changes mid-word, must not disturb the stream
    data_in = 16'h1B4E;
    repeat (60) @(negedge clk);
    tag = "R9";
    for (int i = 0; i < 60; i++) begin
      data_in = lfsr; lfsr = lfsr_next(lfsr);
      @(negedge clk);
    end
    data_in = 16'h1B4E;
    tag = "R4";
    repeat (140) @(negedge clk);

    // R7: enable toggled inside symbols
    tag = "R7";
    for (int i = 0; i < 600; i++) begin
      en = lfsr[3] | lfsr[7];
      data_in = lfsr; lfsr = lfsr_next(lfsr);
      @(negedge clk);
    end
    en = 1'b0;
    @(negedge clk);
    check("R7", int'($signed(sample_out)), 0);

    // R8: back-to-back words with enable held high
    tag = "R8"; en = 1'b1;
    for (int i = 0; i < 1200; i++) begin
      data_in = lfsr; lfsr = lfsr_next(lfsr);
      @(negedge clk);
    end

    // R1: reset in the middle of a word, then a 270-degree start
    do_reset();
    check("R1", int'($signed(sample_out)), 0);
    data_in = 16'hC000; en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R3", int'($signed(sample_out)), -127);
    @(negedge clk);
    check("R2", int'($signed(sample_out)), -49 * 0 + ref_level(13));
    tag = "R2"; cmp_on = 1'b1;
    data_in = 16'h4000;
    repeat (300) @(negedge clk);
    cmp_on = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule